// File: doc/BRIEF.md
# Parallel Camera Pixel Capture

This block takes pixels from a parallel image sensor bus and turns them into a valid/ready stream. The bus has a pixel clock, a vertical sync, an optional horizontal sync and a data word of up to 10 bits. All bus signals are sampled as ordinary inputs in the block's own clock domain, which must run at least twice as fast as the pixel clock. A rising pixel clock edge is found by comparing two successive samples.

A static mode input picks between two qualification schemes. In gated mode a pixel clock edge counts only while the horizontal sync is active, and each active line starts with a horizontal sync edge. In free-running (non-gated) mode every pixel clock edge carries a pixel and the horizontal sync is not used. In both modes a frame starts at the active edge of the vertical sync. Each sync input has its own invert control.

Every output pixel carries a start-of-frame marker and a start-of-line marker. A frame counter counts frame starts. The output holds a single pixel. A pixel that arrives while that slot is still waiting for the consumer is dropped and raises a sticky overflow flag.

Top module: `camCapture`

## Requirements
- R1: While and after reset, outValid is 0, frameCount is 0 and overflow is 0.
- R2: With gatedMode=1, each rising pixClkIn edge seen while the horizontal sync is active yields exactly one output pixel. Rising edges seen while it is inactive yield none.
- R3: With gatedMode=0, every rising pixClkIn edge yields one output pixel whatever hsyncIn does, and outSol is never 1.
- R4: The first pixel accepted after an active vertical sync edge has outSof=1. Later pixels of the same frame have outSof=0.
- R5: With gatedMode=1, the first pixel after each active horizontal sync edge has outSol=1. Later pixels of the same line have outSol=0.
- R6: vsyncInvert=1 (hsyncInvert=1) makes a low level the active level of vsyncIn (hsyncIn), so the falling pin edge is the active edge.
- R7: frameCount rises by exactly one on every active vertical sync edge and wraps from 2^FRAME_W-1 to 0.
- R8: With wideBus=1 the output carries all 10 data bits. With wideBus=0 it carries dataIn[7:0], and outData[9:8] is 0.
- R9: A pixel that arrives while outValid=1 and outReady=0 is discarded and sets overflow. Overflow stays set until overflowClr is 1 for a cycle. A clear wins over a drop in the same cycle.
- R10: While outValid=1 and outReady=0, outValid stays 1 and outData, outSof and outSol do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least twice the pixel clock rate |
| rstN | input | 1 | Active-low synchronous reset |
| gatedMode | input | 1 | 1: horizontal sync qualifies pixels; 0: every pixel clock edge is a pixel |
| wideBus | input | 1 | 1: 10-bit data; 0: 8-bit data |
| vsyncInvert | input | 1 | Treat vsyncIn as active-low |
| hsyncInvert | input | 1 | Treat hsyncIn as active-low |
| pixClkIn | input | 1 | Sensor pixel clock, sampled |
| vsyncIn | input | 1 | Sensor vertical sync |
| hsyncIn | input | 1 | Sensor horizontal sync |
| dataIn | input | 10 | Sensor data word |
| outReady | input | 1 | Consumer accepts the pixel |
| overflowClr | input | 1 | Clears the overflow flag |
| outValid | output | 1 | Output pixel present |
| outData | output | 10 | Output pixel data |
| outSof | output | 1 | Pixel is the first of a frame |
| outSol | output | 1 | Pixel is the first of a line |
| frameCount | output | FRAME_W | Count of frame starts, wrapping |
| overflow | output | 1 | Sticky drop indicator |

## Verification
Gated frames send pixel clock bursts both inside and outside the active horizontal sync. This separates correct qualification from capture on every edge, and it shows whether the line marker lands only on the first pixel of each line. Free-running frames toggle the horizontal sync in the middle of pixel bursts on a narrow bus, so a design that still uses that sync, or leaks the upper data bits, gives a visible mismatch. A run with both syncs inverted, a long train of vertical sync pulses that wraps a narrowed frame counter, and a stalled consumer that receives two pixels cover the polarity, wrap and overflow paths.

// File: rtl/camCapturePkg.sv
package camCapturePkg;
  typedef struct packed {
    logic capture;
    logic sof;
    logic sol;
    logic frameStart;
  } camStrobes_t;
endpackage

// File: rtl/camSyncCtrl.sv
module camSyncCtrl
  import camCapturePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        gatedMode,
  input  logic        vsyncInvert,
  input  logic        hsyncInvert,
  input  logic        pixClkIn,
  input  logic        vsyncIn,
  input  logic        hsyncIn,
  output camStrobes_t strobes
);
  // Sampled copies start at the active level so no edge is seen coming out of reset.
  logic pixQ1, pixQ2, vsQ1, vsQ2, hsQ1, hsQ2;
  logic pendSof, pendSol;
  logic pixRise, vsRise, hsRise, pixelOk, sofNow, solNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixQ1 <= 1'b1; pixQ2 <= 1'b1;
      vsQ1  <= 1'b1; vsQ2  <= 1'b1;
      hsQ1  <= 1'b1; hsQ2  <= 1'b1;
    end else begin
      pixQ1 <= pixClkIn;
      pixQ2 <= pixQ1;
      vsQ1  <= vsyncIn ^ vsyncInvert;
      vsQ2  <= vsQ1;
      hsQ1  <= hsyncIn ^ hsyncInvert;
      hsQ2  <= hsQ1;
    end
  end

  always_comb begin
    pixRise = pixQ1 & ~pixQ2;
    vsRise  = vsQ1 & ~vsQ2;
    hsRise  = hsQ1 & ~hsQ2 & gatedMode;
    pixelOk = pixRise & (~gatedMode | hsQ1);
    sofNow  = pendSof | vsRise;
    solNow  = (pendSol | hsRise) & gatedMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSof <= 1'b0;
      pendSol <= 1'b0;
    end else begin
      pendSof <= pixelOk ? 1'b0 : sofNow;
      pendSol <= pixelOk ? 1'b0 : solNow;
    end
  end

  always_comb begin
    strobes.capture    = pixelOk;
    strobes.sof        = pixelOk & sofNow;
    strobes.sol        = pixelOk & solNow;
    strobes.frameStart = vsRise;
  end
endmodule

// File: rtl/camPixelPath.sv
module camPixelPath
  import camCapturePkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int NARROW_W = 8,
  parameter int FRAME_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wideBus,
  input  logic [DATA_W-1:0]  dataIn,
  input  camStrobes_t        strobes,
  input  logic               outReady,
  input  logic               overflowClr,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outSof,
  output logic               outSol,
  output logic [FRAME_W-1:0] frameCount,
  output logic               overflow
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] dataQ, dataSel;
  logic blocked, drop, load;

  // Aligned with the first sample stage of the pixel clock.
  always_ff @(posedge clk) begin
    if (!rstN) dataQ <= '0;
    else       dataQ <= dataIn;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb dataSel = wideBus ? dataQ : {{PAD_W{1'b0}}, dataQ[NARROW_W-1:0]};
    end else begin : g_nopad
      always_comb dataSel = dataQ;
    end
  endgenerate

  always_comb begin
    blocked = outValid & ~outReady;
    drop    = strobes.capture & blocked;
    load    = strobes.capture & ~blocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outSof   <= 1'b0;
      outSol   <= 1'b0;
    end else if (load) begin
      outValid <= 1'b1;
      outData  <= dataSel;
      outSof   <= strobes.sof;
      outSol   <= strobes.sol;
    end else if (outValid && outReady) begin
      outValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            overflow <= 1'b0;
    else if (overflowClr) overflow <= 1'b0;
    else if (drop)        overflow <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   frameCount <= '0;
    else if (strobes.frameStart) frameCount <= frameCount + 1'b1;
  end
endmodule

// File: rtl/camCapture.sv
module camCapture
  import camCapturePkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int NARROW_W = 8,
  parameter int FRAME_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               gatedMode,
  input  logic               wideBus,
  input  logic               vsyncInvert,
  input  logic               hsyncInvert,
  input  logic               pixClkIn,
  input  logic               vsyncIn,
  input  logic               hsyncIn,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               outReady,
  input  logic               overflowClr,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  output logic               outSof,
  output logic               outSol,
  output logic [FRAME_W-1:0] frameCount,
  output logic               overflow
);
  camStrobes_t strobes;

  camSyncCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .gatedMode(gatedMode),
    .vsyncInvert(vsyncInvert), .hsyncInvert(hsyncInvert),
    .pixClkIn(pixClkIn), .vsyncIn(vsyncIn), .hsyncIn(hsyncIn),
    .strobes(strobes)
  );

  camPixelPath #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .FRAME_W(FRAME_W)) u_path (
    .clk(clk), .rstN(rstN), .wideBus(wideBus), .dataIn(dataIn),
    .strobes(strobes), .outReady(outReady), .overflowClr(overflowClr),
    .outValid(outValid), .outData(outData), .outSof(outSof), .outSol(outSol),
    .frameCount(frameCount), .overflow(overflow)
  );
endmodule

// File: rtl/camCaptureChk.sv
module camCaptureChk #(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               gatedMode,
  input logic               outReady,
  input logic               overflowClr,
  input logic               outValid,
  input logic [DATA_W-1:0]  outData,
  input logic               outSof,
  input logic               outSol,
  input logic [FRAME_W-1:0] frameCount,
  input logic               overflow
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rstN |=> (!outValid && !overflow && frameCount == '0));

  // R3
  no_line_mark_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !gatedMode && $rose(outValid)) |-> !outSol);

  // R7
  frame_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (frameCount == $past(frameCount) || frameCount == FRAME_W'($past(frameCount) + 1'b1)));

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !overflowClr) |=> overflow);

  // R9
  overflow_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowClr |=> !overflow);

  // R10
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSof) && $stable(outSol)));
endmodule

bind camCapture camCaptureChk #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rstN(rstN), .gatedMode(gatedMode), .outReady(outReady),
  .overflowClr(overflowClr), .outValid(outValid), .outData(outData),
  .outSof(outSof), .outSol(outSol), .frameCount(frameCount), .overflow(overflow)
);

// File: tb/camCapture_test.sv
module camCapture_test;
  localparam int FW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gatedMode = 1'b1, wideBus = 1'b1, vsyncInvert = 1'b0, hsyncInvert = 1'b0;
  logic pixClkIn = 1'b0, vsyncIn = 1'b0, hsyncIn = 1'b0;
  logic [9:0] dataIn = '0;
  logic outReady = 1'b1, overflowClr = 1'b0;
  logic outValid, outSof, outSol, overflow;
  logic [9:0] outData;
  logic [FW-1:0] frameCount;

  int checks = 0, errors = 0;
  int expFrames = 0;
  bit expSof = 0, expSol = 0;
  logic [11:0] expQ[$];

  always #10 clk = ~clk;

  camCapture #(.FRAME_W(FW)) uut (
    .clk(clk), .rstN(rstN), .gatedMode(gatedMode), .wideBus(wideBus),
    .vsyncInvert(vsyncInvert), .hsyncInvert(hsyncInvert),
    .pixClkIn(pixClkIn), .vsyncIn(vsyncIn), .hsyncIn(hsyncIn), .dataIn(dataIn),
    .outReady(outReady), .overflowClr(overflowClr), .outValid(outValid),
    .outData(outData), .outSof(outSof), .outSol(outSol),
    .frameCount(frameCount), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops one expected item per handshake.
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2/R3 unexpected pixel", int'(outData), 0);
      end else begin
        logic [11:0] e;
        e = expQ.pop_front();
        check({outSof, outSol, outData} == e, "R2 R3 R4 R5 R8 pixel", int'({outSof, outSol, outData}), int'(e));
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    waitClk(3);
    check(!outValid && frameCount == 0 && !overflow, "R1 reset", int'({outValid, overflow}), 0);
    rstN = 1'b1;
    expFrames = 0; expSof = 0; expSol = 0;
    waitClk(3);
  endtask

  // counts: edge qualifies; accepted: lands in the output slot
  task automatic pix(input logic [9:0] d, input bit counts, input bit accepted);
    logic [9:0] m;
    m = wideBus ? d : (d & 10'h0FF);
    if (counts) begin
      if (accepted) expQ.push_back({expSof, expSol, m});
      expSof = 0; expSol = 0;
    end
    dataIn = d; pixClkIn = 1'b1;
    waitClk(2);
    pixClkIn = 1'b0;
    waitClk(2);
  endtask

  task automatic frameBegin();
    vsyncIn = ~vsyncInvert;
    expFrames++; expSof = 1;
    waitClk(4);
  endtask

  task automatic frameEnd();
    vsyncIn = vsyncInvert;
    waitClk(4);
  endtask

  task automatic lineBegin();
    hsyncIn = ~hsyncInvert;
    if (gatedMode) expSol = 1;
    waitClk(4);
  endtask

  task automatic lineEnd();
    hsyncIn = hsyncInvert;
    waitClk(4);
  endtask

  task automatic drained(input string req);
    waitClk(6);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  initial begin
    doReset();

    // Gated mode, wide bus: R2, R4, R5, R8
    frameBegin();
    pix(10'h3A1, 1'b0, 1'b0);          // hsync inactive: ignored (R2)
    for (int ln = 0; ln < 3; ln++) begin
      lineBegin();
      for (int p = 0; p < 4; p++) pix(10'(10'h300 + ln * 16 + p), 1'b1, 1'b1);
      lineEnd();
      pix(10'h155, 1'b0, 1'b0);        // between lines: ignored (R2)
    end
    frameEnd();
    drained("R2 gated drain");
    check(frameCount == FW'(expFrames), "R7 gated count", frameCount, expFrames);

    // Free-running mode, narrow bus: R3, R8
    gatedMode = 1'b0; wideBus = 1'b0;
    frameBegin();
    for (int p = 0; p < 10; p++) begin
      hsyncIn = p[1];
      pix(10'(10'h2C0 + p * 7), 1'b1, 1'b1);
    end
    hsyncIn = 1'b0;
    frameEnd();
    drained("R3 free drain");

    // Frame counter wrap: R7
    for (int f = 0; f < 20; f++) begin
      frameBegin();
      frameEnd();
    end
    check(frameCount == FW'(expFrames), "R7 wrap", frameCount, expFrames % (1 << FW));
    frameBegin();
    pix(10'h0AB, 1'b1, 1'b1);          // R4 after many empty frames
    frameEnd();
    drained("R4 sof after wrap");

    // Inverted syncs: R6
    gatedMode = 1'b1; wideBus = 1'b1;
    vsyncInvert = 1'b1; hsyncInvert = 1'b1;
    vsyncIn = 1'b1; hsyncIn = 1'b1;
    doReset();
    check(frameCount == 0, "R6 idle high no frame", frameCount, 0);
    frameBegin();
    pix(10'h111, 1'b0, 1'b0);          // hsync pin high = inactive
    lineBegin();
    pix(10'h222, 1'b1, 1'b1);
    pix(10'h233, 1'b1, 1'b1);
    lineEnd();
    frameEnd();
    drained("R6 inverted drain");
    check(frameCount == 1, "R6 inverted frame count", frameCount, 1);

    // Overflow and stall: R9, R10
    frameBegin();
    lineBegin();
    outReady = 1'b0;
    pix(10'h1F0, 1'b1, 1'b1);
    pix(10'h10F, 1'b1, 1'b0);          // dropped
    check(overflow == 1'b1, "R9 overflow set", overflow, 1);
    check(outValid && outData == 10'h1F0 && outSof, "R10 held", int'(outData), 'h1F0);
    outReady = 1'b1;
    waitClk(3);
    check(expQ.size() == 0, "R10 held pixel delivered", expQ.size(), 0);
    check(overflow == 1'b1, "R9 sticky", overflow, 1);
    overflowClr = 1'b1;
    waitClk(1);
    overflowClr = 1'b0;
    waitClk(1);
    check(overflow == 1'b0, "R9 cleared", overflow, 0);
    pix(10'h0F1, 1'b1, 1'b1);
    lineEnd();
    frameEnd();
    drained("R9 after clear");
    check(!overflow, "R9 no new overflow", overflow, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule